// File: doc/BRIEF.md
# Indexed Effective Address Calculator

This block works out the effective address of an indexed operand for a processor front end. The caller pulses a start strobe together with the base register value, a flag that selects program-counter-relative addressing, the address of the first extension word, and two capability inputs. The block then pulls 16-bit words from an instruction-stream port, one word per handshake. The first word is the extension word. Any base displacement words follow it, and then any outer displacement words.

The block decodes two formats. The short format adds base, scaled index and an 8-bit signed offset. The long format can suppress the base or the index and can take 16-bit or 32-bit base and outer displacements. It can also read one 32-bit pointer from memory, with the index added either before or after that read. The index register is read through a combinational register-file port. The pointer is read through a request/response memory port.

When the address is ready the block pulses `done_o` for one cycle. It presents the address on `ea_o` and the number of stream words it used on `words_used_o`, so the caller can advance its program counter. An illegal encoding raises `fault_o` instead. In that case only the extension word is used and no memory read is made.

Top module: `idx_ea_unit`

## Requirements
- R1: With extension bit 8 clear (short format), the address is base + scaled index + bits 7:0 of the extension word taken as a signed 8-bit offset, and no memory read is made.
- R2: The index register is chosen by extension bit 15 (1 = address register, 0 = data register) and bits 14:12 (register number). The block presents it on `reg_addr_o` as {bit15, bits14:12}, so address register n is entry 8+n.
- R3: With extension bit 11 clear, the index is the low 16 bits of the register, sign-extended. With it set, the index is the full 32-bit register. A clear bit 11 while `cap_word_idx_i` is low gives a fault.
- R4: Extension bits 10:9 shift the index left by 0 to 3 bits before it is added.
- R5: Extension bit 8 set while `cap_full_i` is low gives a fault. A fault is signalled by a one-cycle `fault_o` with no `done_o`, no memory request, and `words_used_o` = 1.
- R6: When `pc_rel_i` is set, the base is `ext_addr_i` (the address of the extension word itself), whatever later words are fetched.
- R7: In the long format, bits 5:4 give the base displacement. Code 0 or 1 means none, code 2 means one sign-extended 16-bit word, and code 3 means a 32-bit value sent as two words with the upper half first.
- R8: In the long format, bit 7 set replaces the base (register or pc) with zero.
- R9: In the long format, bit 6 set drops the index. With bit 6 clear, bit 2 = 0 adds the index before the memory read, and bit 2 = 1 adds it to the fetched pointer. With no memory read, bit 2 = 1 means no index is added.
- R10: In the long format, a nonzero value in bits 1:0 reads one 32-bit word at the intermediate address and adds an outer displacement to it. Code 1 adds none, code 2 adds a sign-extended 16-bit word, and code 3 adds a 32-bit value sent upper half first. The memory request stays high with a stable address until the response arrives.
- R11: Stream words are taken only on cycles where `ws_valid_i` and `ws_ready_o` are both high. `ws_ready_o` stays low while the block is idle, and no word beyond the encoding's own count is taken.
- R12: `done_o` is high for exactly one cycle, with `ea_o` holding the result and `words_used_o` giving the number of words used (1 to 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a calculation (taken only when idle) |
| base_i | input | 32 | Base register value |
| pc_rel_i | input | 1 | Use the extension word address as the base |
| ext_addr_i | input | 32 | Address of the extension word |
| cap_word_idx_i | input | 1 | Word-size index permitted |
| cap_full_i | input | 1 | Long format permitted |
| ws_valid_i | input | 1 | Stream word valid |
| ws_data_i | input | 16 | Stream word |
| ws_ready_o | output | 1 | Block will take a stream word |
| reg_addr_o | output | 4 | Index register select {addr/data, number} |
| reg_data_i | input | 32 | Index register value |
| mem_req_o | output | 1 | Pointer read request |
| mem_addr_o | output | 32 | Pointer read address |
| mem_rvalid_i | input | 1 | Pointer read response valid |
| mem_rdata_i | input | 32 | Pointer read data |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle result strobe |
| fault_o | output | 1 | One-cycle illegal-encoding strobe |
| ea_o | output | 32 | Effective address |
| words_used_o | output | 3 | Stream words used |

## Verification
The bench offers five stream words on every run, with gaps in the valid signal. An encoding that needs no displacement, such as base-size code 1, must therefore stop after one word; a design that took extra words would report the wrong count and shift the caller's program counter. Each 32-bit displacement is built from two distinct halves, so swapping the halves gives a visibly wrong address. A negative low half in the index register separates word-size from long-size indexing. One vector sets post-index with no memory read, which catches a design that still adds the index. Further vectors check that the pc base is the first word's address, and that a fault comes with neither a memory read nor a done strobe.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;

  localparam int unsigned WORD_W    = 16;
  localparam int unsigned ADDR_W    = 2 * WORD_W;
  localparam int unsigned MAX_WORDS = 5;
  localparam int unsigned CNT_W     = $clog2(MAX_WORDS + 1);

  typedef enum logic [2:0] {
    S_IDLE,
    S_EXT,
    S_BD,
    S_OD,
    S_CALC,
    S_MEM,
    S_DONE,
    S_FAULT
  } ea_state_e;

  // decoded extension word
  typedef struct packed {
    logic       idx_is_addr;
    logic [2:0] idx_num;
    logic       idx_long;
    logic [1:0] scale;
    logic       full;
    logic       base_sup;
    logic       idx_sup;
    logic       post_sel;
    logic [1:0] bd_sz;
    logic [1:0] ind_sel;
    logic [7:0] d8;
  } ext_fields_t;

endpackage

// File: rtl/idx_ea_decode.sv
module idx_ea_decode
  import idx_ea_pkg::*;
#(
  parameter int unsigned WW = WORD_W
) (
  input  logic [WW-1:0] ext_word_i,
  input  logic          cap_word_idx_i,
  input  logic          cap_full_i,
  output ext_fields_t   fld_o,
  output logic          fault_o,
  output logic [1:0]    bd_words_o,
  output logic [1:0]    od_words_o
);

  always_comb begin
    fld_o.idx_is_addr = ext_word_i[15];
    fld_o.idx_num     = ext_word_i[14:12];
    fld_o.idx_long    = ext_word_i[11];
    fld_o.scale       = ext_word_i[10:9];
    fld_o.full        = ext_word_i[8];
    fld_o.base_sup    = ext_word_i[7];
    fld_o.idx_sup     = ext_word_i[6];
    fld_o.post_sel    = ext_word_i[2];
    fld_o.bd_sz       = ext_word_i[5:4];
    fld_o.ind_sel     = ext_word_i[1:0];
    fld_o.d8          = ext_word_i[7:0];
  end

  assign fault_o = (!ext_word_i[11] && !cap_word_idx_i) ||
                   (ext_word_i[8] && !cap_full_i);

  // displacement word counts only apply to the long format
  always_comb begin
    bd_words_o = 2'd0;
    od_words_o = 2'd0;
    if (ext_word_i[8]) begin
      case (ext_word_i[5:4])
        2'd2:    bd_words_o = 2'd1;
        2'd3:    bd_words_o = 2'd2;
        default: bd_words_o = 2'd0;
      endcase
      case (ext_word_i[1:0])
        2'd2:    od_words_o = 2'd1;
        2'd3:    od_words_o = 2'd2;
        default: od_words_o = 2'd0;
      endcase
    end
  end

endmodule

// File: rtl/idx_ea_index.sv
module idx_ea_index
  import idx_ea_pkg::*;
#(
  parameter int unsigned WW = WORD_W,
  localparam int unsigned AW = 2 * WW
) (
  input  logic          is_addr_i,
  input  logic [2:0]    num_i,
  input  logic          long_i,
  input  logic [1:0]    scale_i,
  input  logic [AW-1:0] reg_data_i,
  output logic [3:0]    reg_addr_o,
  output logic [AW-1:0] idx_o
);

  logic [AW-1:0] sized;

  assign reg_addr_o = {is_addr_i, num_i};
  assign sized = long_i ? reg_data_i
                        : {{(AW-WW){reg_data_i[WW-1]}}, reg_data_i[WW-1:0]};

  always_comb begin
    case (scale_i)
      2'd0:    idx_o = sized;
      2'd1:    idx_o = {sized[AW-2:0], 1'b0};
      2'd2:    idx_o = {sized[AW-3:0], 2'b0};
      default: idx_o = {sized[AW-4:0], 3'b0};
    endcase
  end

endmodule

// File: rtl/idx_ea_unit.sv
module idx_ea_unit
  import idx_ea_pkg::*;
#(
  parameter int unsigned WW = WORD_W,
  localparam int unsigned AW = 2 * WW,
  localparam int unsigned CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic          pc_rel_i,
  input  logic [AW-1:0] ext_addr_i,
  input  logic          cap_word_idx_i,
  input  logic          cap_full_i,
  input  logic          ws_valid_i,
  input  logic [WW-1:0] ws_data_i,
  output logic          ws_ready_o,
  output logic [3:0]    reg_addr_o,
  input  logic [AW-1:0] reg_data_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [AW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fault_o,
  output logic [AW-1:0] ea_o,
  output logic [CW-1:0] words_used_o
);

  // reset: asserted asynchronously, released through two flops
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  ea_state_e     st_q, st_d;
  logic [WW-1:0] ext_q, ext_d;
  logic [AW-1:0] base_q, base_d, xa_q, xa_d;
  logic          pcrel_q, pcrel_d, capw_q, capw_d, capf_q, capf_d;
  logic [AW-1:0] bd_q, bd_d, od_q, od_d, addr_q, addr_d;
  logic [1:0]    left_q, left_d;
  logic [CW-1:0] cnt_q, cnt_d;

  ext_fields_t   fld;
  logic          dec_fault;
  logic [1:0]    bd_words, od_words;
  logic [AW-1:0] idx_val;
  logic          hs;
  logic [AW-1:0] base_sel, wsext, inter, pre_idx, post_idx;

  idx_ea_decode #(.WW(WW)) u_dec (
    .ext_word_i     ((st_q == S_EXT) ? ws_data_i : ext_q),
    .cap_word_idx_i (capw_q),
    .cap_full_i     (capf_q),
    .fld_o          (fld),
    .fault_o        (dec_fault),
    .bd_words_o     (bd_words),
    .od_words_o     (od_words)
  );

  idx_ea_index #(.WW(WW)) u_idx (
    .is_addr_i  (fld.idx_is_addr),
    .num_i      (fld.idx_num),
    .long_i     (fld.idx_long),
    .scale_i    (fld.scale),
    .reg_data_i (reg_data_i),
    .reg_addr_o (reg_addr_o),
    .idx_o      (idx_val)
  );

  assign ws_ready_o = (st_q == S_EXT) || (st_q == S_BD) || (st_q == S_OD);
  assign hs         = ws_ready_o && ws_valid_i;
  assign wsext      = {{(AW-WW){ws_data_i[WW-1]}}, ws_data_i};
  assign base_sel   = pcrel_q ? xa_q : base_q;
  assign pre_idx    = (!fld.idx_sup && !fld.post_sel) ? idx_val : '0;
  assign post_idx   = (!fld.idx_sup &&  fld.post_sel) ? idx_val : '0;
  assign inter      = (fld.base_sup ? '0 : base_sel) + bd_q + pre_idx;

  // next-state process
  always_comb begin
    st_d    = st_q;
    ext_d   = ext_q;
    base_d  = base_q;
    xa_d    = xa_q;
    pcrel_d = pcrel_q;
    capw_d  = capw_q;
    capf_d  = capf_q;
    bd_d    = bd_q;
    od_d    = od_q;
    addr_d  = addr_q;
    left_d  = left_q;
    cnt_d   = cnt_q;
    case (st_q)
      S_IDLE: if (start_i) begin
        st_d    = S_EXT;
        base_d  = base_i;
        xa_d    = ext_addr_i;
        pcrel_d = pc_rel_i;
        capw_d  = cap_word_idx_i;
        capf_d  = cap_full_i;
        bd_d    = '0;
        od_d    = '0;
        cnt_d   = '0;
      end
      S_EXT: if (hs) begin
        ext_d = ws_data_i;
        cnt_d = cnt_q + 1'b1;
        if (dec_fault)            st_d = S_FAULT;
        else if (!fld.full)       st_d = S_CALC;
        else if (bd_words != 2'd0) begin
          st_d = S_BD; left_d = bd_words;
        end else if (od_words != 2'd0) begin
          st_d = S_OD; left_d = od_words;
        end else                  st_d = S_CALC;
      end
      S_BD: if (hs) begin
        cnt_d  = cnt_q + 1'b1;
        left_d = left_q - 2'd1;
        if (fld.bd_sz == 2'd2)  bd_d = wsext;
        else if (left_q == 2'd2) bd_d = {ws_data_i, bd_q[WW-1:0]};
        else                     bd_d = {bd_q[AW-1:WW], ws_data_i};
        if (left_q == 2'd1) begin
          if (od_words != 2'd0) begin
            st_d = S_OD; left_d = od_words;
          end else st_d = S_CALC;
        end
      end
      S_OD: if (hs) begin
        cnt_d  = cnt_q + 1'b1;
        left_d = left_q - 2'd1;
        if (fld.ind_sel == 2'd2) od_d = wsext;
        else if (left_q == 2'd2)  od_d = {ws_data_i, od_q[WW-1:0]};
        else                      od_d = {od_q[AW-1:WW], ws_data_i};
        if (left_q == 2'd1) st_d = S_CALC;
      end
      S_CALC: begin
        if (!fld.full) begin
          addr_d = base_sel + idx_val + {{(AW-8){fld.d8[7]}}, fld.d8};
          st_d   = S_DONE;
        end else begin
          addr_d = inter;
          st_d   = (fld.ind_sel != 2'd0) ? S_MEM : S_DONE;
        end
      end
      S_MEM: if (mem_rvalid_i) begin
        addr_d = mem_rdata_i + od_q + post_idx;
        st_d   = S_DONE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q    <= S_IDLE;
      ext_q   <= '0;
      base_q  <= '0;
      xa_q    <= '0;
      pcrel_q <= 1'b0;
      capw_q  <= 1'b0;
      capf_q  <= 1'b0;
      bd_q    <= '0;
      od_q    <= '0;
      addr_q  <= '0;
      left_q  <= '0;
      cnt_q   <= '0;
    end else begin
      st_q    <= st_d;
      ext_q   <= ext_d;
      base_q  <= base_d;
      xa_q    <= xa_d;
      pcrel_q <= pcrel_d;
      capw_q  <= capw_d;
      capf_q  <= capf_d;
      bd_q    <= bd_d;
      od_q    <= od_d;
      addr_q  <= addr_d;
      left_q  <= left_d;
      cnt_q   <= cnt_d;
    end
  end

  assign mem_req_o    = (st_q == S_MEM);
  assign mem_addr_o   = addr_q;
  assign busy_o       = (st_q != S_IDLE);
  assign done_o       = (st_q == S_DONE);
  assign fault_o      = (st_q == S_FAULT);
  assign ea_o         = addr_q;
  assign words_used_o = cnt_q;

  p_strobe_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !(done_o && fault_o));
  p_fault_one_word_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    fault_o |-> (words_used_o == CW'(1)));
  p_mem_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));
  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    done_o |=> !done_o);
  p_word_bound_r11: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    done_o |-> (words_used_o >= CW'(1) && words_used_o <= CW'(MAX_WORDS)));

endmodule

// File: tb/sim_idx_ea_unit.sv
`timescale 1ns/100ps
module sim_idx_ea_unit;

  typedef struct packed {
    logic [15:0] ext;
    logic [63:0] tail;
    logic [31:0] base;
    logic        pcrel;
    logic        capw;
    logic        capf;
    logic        xfault;
    logic [2:0]  xwords;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{16'h2805, 64'h0,                   32'h0000_1000, 1'b0, 1'b1, 1'b1, 1'b0, 3'd1},
    '{16'hB4FC, 64'h0,                   32'h0000_2000, 1'b0, 1'b1, 1'b1, 1'b0, 3'd1},
    '{16'h3010, 64'h0,                   32'h0000_0100, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1},
    '{16'h2910, 64'h0,                   32'h0000_0100, 1'b0, 1'b1, 1'b0, 1'b1, 3'd1},
    '{16'h1920, 64'hFF80_0000_0000_0000, 32'h0000_3000, 1'b0, 1'b1, 1'b1, 1'b0, 3'd2},
    '{16'h19F0, 64'h1234_5678_0000_0000, 32'h0000_3000, 1'b0, 1'b1, 1'b1, 1'b0, 3'd3},
    '{16'h4B11, 64'h0,                   32'h0000_5000, 1'b0, 1'b1, 1'b1, 1'b0, 3'd1},
    '{16'hEF26, 64'h0040_FFF0_0000_0000, 32'h0000_6000, 1'b0, 1'b1, 1'b1, 1'b0, 3'd3},
    '{16'h0973, 64'h0001_0002_8000_0004, 32'h0000_7000, 1'b1, 1'b1, 1'b1, 1'b0, 3'd5},
    '{16'hA880, 64'h0,                   32'h0000_9000, 1'b1, 1'b1, 1'b1, 1'b0, 3'd1},
    '{16'h0950, 64'hAAAA_BBBB_CCCC_DDDD, 32'h0ABC_DEF0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd1},
    '{16'hD110, 64'h0,                   32'h0010_0000, 1'b0, 1'b1, 1'b1, 1'b0, 3'd1},
    '{16'h0914, 64'h0,                   32'h0000_2222, 1'b0, 1'b1, 1'b1, 1'b0, 3'd1},
    '{16'h2922, 64'h0010_0008_0000_0000, 32'h0000_0000, 1'b1, 1'b1, 1'b1, 1'b0, 3'd3},
    '{16'h7100, 64'h0,                   32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] base, ext_addr;
  logic        pc_rel, capw, capf;
  logic        ws_valid;
  logic [15:0] ws_data;
  logic        ws_ready;
  logic [3:0]  reg_addr;
  logic [31:0] reg_data;
  logic        mem_req, mem_rvalid;
  logic [31:0] mem_addr, mem_rdata;
  logic        busy, done, fault;
  logic [31:0] ea;
  logic [2:0]  words_used;

  logic [31:0] regs [16];
  logic [15:0] cur_w [5];
  logic        stream_en = 1'b0;
  logic        idle_valid = 1'b0;
  int          widx = 0;
  logic        hs = 1'b0;
  int          cyc = 0;
  int          lat = 0;
  int          mem_cnt = 0;
  logic [31:0] mem_last = '0;
  int          checks = 0;
  int          fails = 0;

  always #2.5 clk = ~clk;

  assign reg_data = regs[reg_addr];

  idx_ea_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base),
    .pc_rel_i(pc_rel), .ext_addr_i(ext_addr), .cap_word_idx_i(capw),
    .cap_full_i(capf), .ws_valid_i(ws_valid), .ws_data_i(ws_data),
    .ws_ready_o(ws_ready), .reg_addr_o(reg_addr), .reg_data_i(reg_data),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .busy_o(busy), .done_o(done), .fault_o(fault),
    .ea_o(ea), .words_used_o(words_used)
  );

  function automatic logic [31:0] mem_fn(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h0F0F_3C3C;
  endfunction

  task automatic check(input logic ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", what, act, exp);
    end
  endtask

  // independent model built from the requirements
  task automatic model(input logic [15:0] e, input logic [63:0] t,
                       input logic [31:0] b, input logic pc, input logic [31:0] xa,
                       input logic cw, input logic cf,
                       output logic f, output logic [2:0] n, output logic [31:0] r_ea,
                       output logic mr, output logic [31:0] ma);
    logic [31:0] r, v, bd, od, bv, inter;
    logic [15:0] w [5];
    int k;
    w[0] = e; w[1] = t[63:48]; w[2] = t[47:32]; w[3] = t[31:16]; w[4] = t[15:0];
    r = regs[{e[15], e[14:12]}];
    v = e[11] ? r : {{16{r[15]}}, r[15:0]};
    v = v << e[10:9];
    f = 1'b0; n = 3'd1; r_ea = '0; mr = 1'b0; ma = '0;
    if ((!e[11] && !cw) || (e[8] && !cf)) begin f = 1'b1; return; end
    if (!e[8]) begin
      r_ea = (pc ? xa : b) + v + {{24{e[7]}}, e[7:0]};
      return;
    end
    k = 1; bd = '0; od = '0;
    if (e[5:4] == 2'd2) begin bd = {{16{w[k][15]}}, w[k]}; k++; end
    else if (e[5:4] == 2'd3) begin bd = {w[k], w[k+1]}; k += 2; end
    if (e[1:0] == 2'd2) begin od = {{16{w[k][15]}}, w[k]}; k++; end
    else if (e[1:0] == 2'd3) begin od = {w[k], w[k+1]}; k += 2; end
    n = k[2:0];
    bv = e[7] ? 32'h0 : (pc ? xa : b);
    inter = bv + bd + ((!e[6] && !e[2]) ? v : 32'h0);
    if (e[1:0] == 2'd0) r_ea = inter;
    else begin
      mr = 1'b1; ma = inter;
      r_ea = mem_fn(inter) + od + ((!e[6] && e[2]) ? v : 32'h0);
    end
  endtask

  // stream source: five words on offer, valid with gaps
  initial begin
    ws_valid = 1'b0; ws_data = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (hs) widx++;
      ws_valid = idle_valid || (stream_en && widx < 5 && (cyc % 3) != 1);
      ws_data  = (widx < 5) ? cur_w[widx] : 16'h0;
      #0.5;
      hs = ws_valid && ws_ready && stream_en;
    end
  end

  // memory responder, two-cycle latency
  initial begin
    mem_rvalid = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (!mem_req) lat = 0;
      else begin
        lat++;
        if (lat == 2) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mem_fn(mem_addr);
          mem_last   = mem_addr;
          mem_cnt++;
          lat = 0;
        end
      end
    end
  end

  task automatic run_one(input logic [15:0] e, input logic [63:0] t,
                         input logic [31:0] b, input logic pc, input logic [31:0] xa,
                         input logic cw, input logic cf,
                         output logic g_done, output logic g_fault,
                         output logic [31:0] g_ea, output logic [2:0] g_words,
                         output int g_used);
    @(negedge clk); #1;
    cur_w[0] = e; cur_w[1] = t[63:48]; cur_w[2] = t[47:32];
    cur_w[3] = t[31:16]; cur_w[4] = t[15:0];
    widx = 0; hs = 1'b0; mem_cnt = 0;
    base = b; pc_rel = pc; ext_addr = xa; capw = cw; capf = cf;
    start = 1'b1; stream_en = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    g_done = 1'b0; g_fault = 1'b0; g_ea = '0; g_words = '0;
    for (int i = 0; i < 80; i++) begin
      if (done || fault) begin
        g_done = done; g_fault = fault; g_ea = ea; g_words = words_used;
        break;
      end
      @(negedge clk); #1;
    end
    stream_en = 1'b0;
    g_used = widx;
    @(negedge clk); #1;
    check(!done && !fault, "R12 strobe lasts one cycle", {30'h0, done, fault}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic gd, gf, xf, xmr;
    logic [31:0] gea, xea, xma;
    logic [2:0] gw, xw;
    int gu;
    for (int i = 0; i < 16; i++) regs[i] = (i < 8) ? 32'h10 * (i + 1) : 32'h0100_0000 + (i - 8) * 32'h100;
    regs[3]  = 32'h1234_FFF0;
    regs[13] = 32'h0000_8000;
    rst_n = 1'b0; start = 1'b0; base = '0; pc_rel = 1'b0; ext_addr = '0;
    capw = 1'b0; capf = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(!done && !fault && !busy && !mem_req && !ws_ready, "R12 reset outputs quiet",
          {27'h0, done, fault, busy, mem_req, ws_ready}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: idle block ignores offered words
    idle_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      check(!ws_ready && !busy, "R11 no stream take when idle", {30'h0, ws_ready, busy}, 32'h0);
    end
    idle_valid = 1'b0;

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [31:0] xa;
      xa = 32'h4000 + v * 16;
      model(VECS[v].ext, VECS[v].tail, VECS[v].base, VECS[v].pcrel, xa,
            VECS[v].capw, VECS[v].capf, xf, xw, xea, xmr, xma);
      run_one(VECS[v].ext, VECS[v].tail, VECS[v].base, VECS[v].pcrel, xa,
              VECS[v].capw, VECS[v].capf, gd, gf, gea, gw, gu);
      check(gf == VECS[v].xfault && gd == !VECS[v].xfault && xf == VECS[v].xfault,
            "R5 fault/done outcome", {30'h0, gd, gf}, {30'h0, !VECS[v].xfault, VECS[v].xfault});
      check(gw == VECS[v].xwords && xw == VECS[v].xwords, "R7 R10 words used",
            {29'h0, gw}, {29'h0, VECS[v].xwords});
      check(gu == int'(VECS[v].xwords), "R11 stream words taken",
            gu, {29'h0, VECS[v].xwords});
      check(mem_cnt == (xmr ? 1 : 0), "R10 memory read count", mem_cnt, {31'h0, xmr});
      if (xmr)
        check(mem_last == xma, "R9 R10 pointer address", mem_last, xma);
      if (!xf)
        check(gea == xea, "R1 R8 R9 effective address", gea, xea);
    end

    // directed, hand-computed
    run_one(16'h2805, 64'h0, 32'h1000, 1'b0, 32'h0, 1'b1, 1'b1, gd, gf, gea, gw, gu);
    check(gd && gea == 32'h1035, "R1 R2 short format data reg", gea, 32'h1035);
    run_one(16'h3000, 64'h0, 32'h100, 1'b0, 32'h0, 1'b1, 1'b1, gd, gf, gea, gw, gu);
    check(gd && gea == 32'h0F0, "R3 word index sign-extended", gea, 32'h0F0);
    run_one(16'h0E00, 64'h0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b1, gd, gf, gea, gw, gu);
    check(gd && gea == 32'h80, "R4 scale by eight", gea, 32'h80);
    run_one(16'hA880, 64'h0, 32'h9000, 1'b1, 32'h4000, 1'b1, 1'b1, gd, gf, gea, gw, gu);
    check(gd && gea == 32'h0100_4180, "R6 pc base is first word", gea, 32'h0100_4180);
    run_one(16'h19F0, 64'h1234_5678_0000_0000, 32'h3000, 1'b0, 32'h0, 1'b1, 1'b1,
            gd, gf, gea, gw, gu);
    check(gd && gea == 32'h1234_5678, "R7 R8 32-bit base disp upper first", gea, 32'h1234_5678);
    run_one(16'h2913, 64'h0001_0002_0003_0004, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0,
            gd, gf, gea, gw, gu);
    check(gf && !gd && mem_cnt == 0 && gw == 3'd1 && gu == 1, "R5 fault takes nothing more",
          {mem_cnt[15:0], 13'h0, gw}, 32'h0000_0001);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule